// File: doc/BRIEF.md
# Device Wake and Access Arbiter

This block sits between a host register port and an internal processor domain that can be powered down. The host reads one control/status word and writes two request bits in it: an init-done bit that moves the device into full operation, and an access-request bit that keeps the domain awake while the host reaches internal resources. A small state machine drives a power request to the domain and waits for its acknowledge before it reports the domain's clock as ready. When the access request is clear for a configurable number of idle cycles, the machine announces a going-to-sleep phase, drops the power request and returns to the powered-down state once the acknowledge falls.

The same word reports a power-save type code and a synchronized copy of an external RF-kill switch. A one-cycle software reset, written to a second register address, clears both host request bits and forces the domain down. The `access_granted` output tells the host in one signal when internal access is safe.

Top module: `wake_arb`

## Requirements
- R1: After reset, `rd_data` reads all zeros when `rfkill_in` is low, and `pwr_req` and `access_granted` are 0.
- R2: A write with `wr_addr`=0 stores only bit 2 (init-done) and bit 3 (access request). Bits 0, 4, 24-26 and 27 are read-only status and ignore the written value.
- R3: Clock-ready (bit 0) stays 0 while init-done is 0. An access request without init-done does not raise `pwr_req`. One cycle after init-done reads 0, bit 0 reads 0.
- R4: With init-done set, `pwr_req` rises in the cycle after the write. Bit 0 rises in the cycle after `pwr_ack` is first seen high.
- R5: While access request, init-done and `pwr_ack` are all 1, the domain stays awake however long the request is held.
- R6: With access request clear and init-done set, the awake domain enters going-to-sleep (bit 4) after exactly IDLE_CYCLES cycles. It drops `pwr_req` while bit 4 is set and holds bit 4 until `pwr_ack` falls. It then reads bit 0 = 0, bit 4 = 0, and it stays down.
- R7: An access request that arrives during going-to-sleep does not cut the sleep short. The domain passes through a cycle with bits 0 and 4 both 0, then wakes again.
- R8: `access_granted` is 1 exactly when bit 0 is 1 and bit 4 is 0. It implies that `pwr_req` is 1.
- R9: Bits 26:24 hold the power-save type: 0 = none (awake with the radio on, or not initialised); 1 = processor down (init-done set and the domain not awake); 2 = radio down (awake and `radio_pd` high); 3 = error. The error code is latched when `pwr_ack` falls while the domain is awake, and it stays until a software reset.
- R10: A write with `wr_addr`=1 and bit 7 set is a software reset. It clears init-done, the access request and the error code, puts an awake domain into going-to-sleep in the next cycle, and leaves it down.
- R11: Bit 27 equals `rfkill_in` as it was SYNC_STAGES cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = control word, 1 = reset register |
| wr_data | input | DATA_W | Write data |
| rd_data | output | DATA_W | Control/status word |
| rfkill_in | input | 1 | Asynchronous RF-kill switch level |
| radio_pd | input | 1 | Domain reports its radio powered down |
| pwr_req | output | 1 | Power-up request to the domain |
| pwr_ack | input | 1 | Domain power acknowledge |
| access_granted | output | 1 | Host may touch internal resources |

## Verification
The hardest situation to reach is an access request that lands inside the short going-to-sleep window. The bench's domain stub answers with a fixed three-cycle acknowledge delay, so the window has a known length. The bench clears the request, polls until bit 4 appears, and writes the request back in the very next cycle. A second hard case is an acknowledge lost while the domain is awake. The stub has a forced-drop control that cuts the acknowledge for one cycle, and the bench then checks that the error code survives the re-wake and clears only on a software reset.

// File: rtl/wake_arb_pkg.sv
package wake_arb_pkg;

   typedef enum logic [1:0] {
      DOM_DOWN     = 2'd0,
      DOM_WAKING   = 2'd1,
      DOM_AWAKE    = 2'd2,
      DOM_SLEEPING = 2'd3
   } dom_state_e;

   typedef enum logic [2:0] {
      PS_NONE  = 3'd0,
      PS_PROC  = 3'd1,
      PS_RADIO = 3'd2,
      PS_ERROR = 3'd3
   } psave_e;

   // bit positions in the control/status word
   localparam int CTL_CLK_RDY  = 0;
   localparam int CTL_INIT     = 2;
   localparam int CTL_ACCESS   = 3;
   localparam int CTL_SLEEPING = 4;
   localparam int CTL_PSAVE_LO = 24;
   localparam int CTL_RFKILL   = 27;
   localparam int CTL_MIN_W    = CTL_RFKILL + 1;

   // bit position in the reset register
   localparam int RST_SW       = 7;

endpackage

// File: rtl/wake_arb_sync.sv
module wake_arb_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '0;
               else        chain_q <= d;
            end
         end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q <= '0;
               else        chain_q <= {chain_q[STAGES-2:0], d};
            end
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/wake_arb_host_regs.sv
module wake_arb_host_regs
   import wake_arb_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clk_ready,
   output logic              init_q,
   output logic              access_q,
   output logic              boot_pend_q,
   output logic              sw_rst
);

   logic ctl_wr;
   logic rst_wr;

   assign ctl_wr = wr_en && !wr_addr;
   assign rst_wr = wr_en &&  wr_addr;
   assign sw_rst = rst_wr && wr_data[RST_SW];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         init_q      <= 1'b0;
         access_q    <= 1'b0;
         boot_pend_q <= 1'b0;
      end else if (sw_rst) begin
         init_q      <= 1'b0;
         access_q    <= 1'b0;
         boot_pend_q <= 1'b0;
      end else if (ctl_wr) begin
         init_q      <= wr_data[CTL_INIT];
         access_q    <= wr_data[CTL_ACCESS];
         if (!init_q && wr_data[CTL_INIT]) boot_pend_q <= 1'b1;
         else if (!wr_data[CTL_INIT])      boot_pend_q <= 1'b0;
      end else if (clk_ready) begin
         boot_pend_q <= 1'b0;
      end
   end

endmodule

// File: rtl/wake_arb_fsm.sv
module wake_arb_fsm
   import wake_arb_pkg::*;
#(
   parameter int IDLE_CYCLES = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       init_q,
   input  logic       access_q,
   input  logic       boot_pend,
   input  logic       sw_rst,
   input  logic       pwr_ack,
   input  logic       radio_pd,
   output logic       clk_ready,
   output logic       going_sleep,
   output logic       pwr_req,
   output logic [2:0] psave
);

   dom_state_e st_q;
   dom_state_e st_d;
   logic       idle_hit;
   logic       err_q;
   logic       awake;

   assign awake = (st_q == DOM_AWAKE);

   generate
      if (IDLE_CYCLES == 0) begin : g_no_idle
         assign idle_hit = 1'b0;
      end else begin : g_idle
         localparam int CNT_W = $clog2(IDLE_CYCLES + 1);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(IDLE_CYCLES - 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     cnt_q <= '0;
            else if (awake && !access_q)    cnt_q <= idle_hit ? cnt_q : cnt_q + CNT_W'(1);
            else                            cnt_q <= '0;
         end
         assign idle_hit = awake && !access_q && (cnt_q == CNT_LAST);
      end
   endgenerate

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         DOM_DOWN: begin
            if (init_q && (access_q || boot_pend) && !sw_rst) st_d = DOM_WAKING;
         end
         DOM_WAKING: begin
            if (sw_rst || !init_q) st_d = DOM_SLEEPING;
            else if (pwr_ack)      st_d = DOM_AWAKE;
         end
         DOM_AWAKE: begin
            if (sw_rst || !init_q || !pwr_ack || idle_hit) st_d = DOM_SLEEPING;
         end
         DOM_SLEEPING: begin
            if (!pwr_ack) st_d = DOM_DOWN;
         end
         default: st_d = DOM_DOWN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= DOM_DOWN;
         err_q <= 1'b0;
      end else begin
         st_q <= st_d;
         if (sw_rst)                err_q <= 1'b0;
         else if (awake && !pwr_ack) err_q <= 1'b1;
      end
   end

   assign clk_ready   = awake;
   assign going_sleep = (st_q == DOM_SLEEPING);
   assign pwr_req     = (st_q == DOM_WAKING) || awake;

   always_comb begin
      if (err_q)      psave = PS_ERROR;
      else if (awake) psave = radio_pd ? PS_RADIO : PS_NONE;
      else            psave = init_q ? PS_PROC : PS_NONE;
   end

endmodule

// File: rtl/wake_arb.sv
module wake_arb
   import wake_arb_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter int IDLE_CYCLES = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              rfkill_in,
   input  logic              radio_pd,
   output logic              pwr_req,
   input  logic              pwr_ack,
   output logic              access_granted
);

   generate
      if (DATA_W < CTL_MIN_W) begin : g_bad_width
         $error("wake_arb: DATA_W must hold bit %0d", CTL_RFKILL);
      end
      if (IDLE_CYCLES < 0) begin : g_bad_idle
         $error("wake_arb: IDLE_CYCLES must not be negative");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("wake_arb: SYNC_STAGES must be 0 to 4");
      end
   endgenerate

   logic       init_q;
   logic       access_q;
   logic       boot_pend;
   logic       sw_rst;
   logic       clk_ready;
   logic       going_sleep;
   logic [2:0] psave;
   logic       rfkill_s;

   wake_arb_host_regs #(.DATA_W(DATA_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .clk_ready   (clk_ready),
      .init_q      (init_q),
      .access_q    (access_q),
      .boot_pend_q (boot_pend),
      .sw_rst      (sw_rst)
   );

   wake_arb_fsm #(.IDLE_CYCLES(IDLE_CYCLES)) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_q      (init_q),
      .access_q    (access_q),
      .boot_pend   (boot_pend),
      .sw_rst      (sw_rst),
      .pwr_ack     (pwr_ack),
      .radio_pd    (radio_pd),
      .clk_ready   (clk_ready),
      .going_sleep (going_sleep),
      .pwr_req     (pwr_req),
      .psave       (psave)
   );

   wake_arb_sync #(.STAGES(SYNC_STAGES)) u_rfkill_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (rfkill_in),
      .q     (rfkill_s)
   );

   always_comb begin
      rd_data                     = '0;
      rd_data[CTL_CLK_RDY]        = clk_ready;
      rd_data[CTL_INIT]           = init_q;
      rd_data[CTL_ACCESS]         = access_q;
      rd_data[CTL_SLEEPING]       = going_sleep;
      rd_data[CTL_PSAVE_LO +: 3]  = psave;
      rd_data[CTL_RFKILL]         = rfkill_s;
   end

   assign access_granted = clk_ready && !going_sleep;

endmodule

// File: rtl/wake_arb_chk.sv
module wake_arb_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic              wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic [DATA_W-1:0] rd_data,
   input logic              pwr_req,
   input logic              pwr_ack,
   input logic              access_granted
);

   // R3
   init_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_data[2] |=> !rd_data[0]);

   // R4
   ready_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_data[0]) |-> ($past(pwr_ack) && $past(pwr_req)));

   // R5
   hold_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data[0] && rd_data[2] && rd_data[3] && pwr_ack && !(wr_en && wr_addr))
      |=> rd_data[0]);

   // R6
   sleep_drops_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_data[4] |-> !pwr_req);

   // R8
   grant_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      access_granted |-> (pwr_req && !rd_data[4] && rd_data[0]));

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((rd_data[26:24] == 3'd3) && !(wr_en && wr_addr && wr_data[7]))
      |=> (rd_data[26:24] == 3'd3));

endmodule

bind wake_arb wake_arb_chk #(.DATA_W(DATA_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .wr_en          (wr_en),
   .wr_addr        (wr_addr),
   .wr_data        (wr_data),
   .rd_data        (rd_data),
   .pwr_req        (pwr_req),
   .pwr_ack        (pwr_ack),
   .access_granted (access_granted)
);

// File: tb/wake_arb_bench.sv
`timescale 1ns/1ps
module wake_arb_bench;

   localparam int DW   = 32;
   localparam int IDLE = 4;
   localparam int SYNC = 2;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic          wr_addr = 1'b0;
   logic [DW-1:0] wr_data = '0;
   logic [DW-1:0] rd_data;
   logic          rfkill_in = 1'b0;
   logic          radio_pd = 1'b0;
   logic          pwr_req;
   logic          pwr_ack;
   logic          access_granted;
   logic          force_drop = 1'b0;
   logic [2:0]    ack_pipe;

   int n_chk  = 0;
   int n_bad  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   // domain stub: acknowledge follows request after three cycles
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_pipe <= '0;
      else        ack_pipe <= {ack_pipe[1:0], pwr_req};
   end
   assign pwr_ack = ack_pipe[2] && !force_drop;

   wake_arb #(.DATA_W(DW), .IDLE_CYCLES(IDLE), .SYNC_STAGES(SYNC)) u_wake_arb (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_data(rd_data), .rfkill_in(rfkill_in),
      .radio_pd(radio_pd), .pwr_req(pwr_req), .pwr_ack(pwr_ack),
      .access_granted(access_granted)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called at a negedge; returns at the negedge after the write edge
   task automatic wr(input logic a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_addr = 1'b0; wr_data = '0;
   endtask

   task automatic poll_ready(output int n);
      n = 0;
      while (!rd_data[0] && n < 100) begin @(negedge clk); n++; end
   endtask

   task automatic poll_sleep(output int n);
      n = 0;
      while (!rd_data[4] && n < 100) begin @(negedge clk); n++; end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
      finish_run();
   end

   initial begin
      int n;
      int hits;
      bit gap;
      bit bad_req;
      logic [7:0] pat;
      logic prev;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      check("R1 rd_data", rd_data, 32'h0);
      check("R1 pwr_req", {31'd0, pwr_req}, 32'd0);
      check("R1 access_granted", {31'd0, access_granted}, 32'd0);

      // R2 only bits 2,3 stored; status bits read-only
      for (int i = 0; i < 32; i++) begin
         logic [31:0] w;
         logic [31:0] e;
         w = {4'd0, i[4], 18'd0, i[3], i[2], i[1], 1'b0, i[0]};
         wr(1'b0, w);
         e = (w & 32'hC) | (w[2] ? 32'h0100_0000 : 32'h0);
         check("R2 write mask", rd_data, e);
         wr(1'b1, 32'h80);
         repeat (12) @(negedge clk);
      end

      // R3 access request without init-done does not wake
      wr(1'b0, 32'h8);
      hits = 0;
      for (int k = 0; k < 10; k++) begin
         @(negedge clk);
         if (pwr_req || rd_data[0]) hits++;
      end
      check("R3 no wake without init", hits, 0);

      // R4 wake latency: req next cycle, ready one cycle after ack
      wr(1'b0, 32'hC);
      check("R4 pwr_req after write", {31'd0, pwr_req}, 32'd0);
      @(negedge clk);
      check("R4 pwr_req raised", {31'd0, pwr_req}, 32'd1);
      n = 1;
      while (!rd_data[0] && n < 100) begin @(negedge clk); n++; end
      check("R4 ready latency", n, 5);
      check("R8 granted when awake", {31'd0, access_granted}, 32'd1);

      // R5 request holds the domain awake
      hits = 0;
      for (int k = 0; k < 4 * IDLE + 6; k++) begin
         @(negedge clk);
         if (!rd_data[0]) hits++;
      end
      check("R5 stays awake", hits, 0);

      // R9 radio-down and none codes
      radio_pd = 1'b1;
      @(negedge clk);
      check("R9 radio code", {29'd0, rd_data[26:24]}, 32'd2);
      radio_pd = 1'b0;
      @(negedge clk);
      check("R9 none code", {29'd0, rd_data[26:24]}, 32'd0);

      // R6 idle sleep after IDLE cycles
      wr(1'b0, 32'h4);
      poll_sleep(n);
      check("R6 idle count", n, IDLE);
      check("R6 req dropped", {31'd0, pwr_req}, 32'd0);
      check("R8 no grant while sleeping", {31'd0, access_granted}, 32'd0);
      n = 0;
      while (rd_data[4] && n < 100) begin @(negedge clk); n++; end
      check("R6 sleep hold", n, 4);
      check("R6 down bits", {27'd0, rd_data[4:0]}, 32'h4);
      check("R9 processor-down code", {29'd0, rd_data[26:24]}, 32'd1);
      hits = 0;
      for (int k = 0; k < 12; k++) begin
         @(negedge clk);
         if (rd_data[0] || pwr_req) hits++;
      end
      check("R6 stays down", hits, 0);

      // R7 request arriving during going-to-sleep
      wr(1'b0, 32'hC);
      poll_ready(n);
      wr(1'b0, 32'h4);
      poll_sleep(n);
      wr(1'b0, 32'hC);
      gap = 1'b0; bad_req = 1'b0; n = 0;
      while (!rd_data[0] && n < 100) begin
         if (rd_data[4] && pwr_req) bad_req = 1'b1;
         if (!rd_data[4] && !rd_data[0]) gap = 1'b1;
         @(negedge clk); n++;
      end
      check("R7 sleep not cut", {31'd0, bad_req}, 32'd0);
      check("R7 passed through down", {31'd0, gap}, 32'd1);
      check("R7 woke again", {31'd0, rd_data[0]}, 32'd1);

      // R9 error latched on acknowledge loss
      force_drop = 1'b1;
      @(negedge clk);
      force_drop = 1'b0;
      check("R9 error code", {29'd0, rd_data[26:24]}, 32'd3);
      check("R8 no grant on loss", {31'd0, access_granted}, 32'd0);
      repeat (20) @(negedge clk);
      check("R9 error sticky", {29'd0, rd_data[26:24]}, 32'd3);

      // R10 software reset
      check("R10 awake before reset", {31'd0, rd_data[0]}, 32'd1);
      wr(1'b1, 32'h80);
      check("R10 going to sleep", {31'd0, rd_data[4]}, 32'd1);
      check("R10 requests cleared", {30'd0, rd_data[3:2]}, 32'd0);
      check("R10 error cleared", {29'd0, rd_data[26:24]}, 32'd0);
      hits = 0;
      for (int k = 0; k < 20; k++) begin
         @(negedge clk);
         if (rd_data[0]) hits++;
      end
      check("R10 stays down", hits, 0);
      check("R10 final word", rd_data, 32'h0);

      // R11 RF-kill mirror latency
      pat = 8'b1011_0010;
      prev = 1'b0;
      for (int k = 0; k < 8; k++) begin
         rfkill_in = pat[k];
         @(negedge clk);
         check("R11 before sync", {31'd0, rd_data[27]}, {31'd0, prev});
         @(negedge clk);
         check("R11 after sync", {31'd0, rd_data[27]}, {31'd0, pat[k]});
         prev = pat[k];
      end

      finish_run();
   end

endmodule